// File: doc/BRIEF.md
# Bit Test, Modify and Scan Unit

This block performs single-bit operations, a masked AND test and bit searches on a 64-bit operand. Each request presents an operation code, a first operand and a second operand. The second operand is either a mask or a bit index, depending on the operation. The result appears on registered outputs one cycle after the request is accepted.

The outputs are:
- the operand after any bit modification,
- a 6-bit bit position produced by the scans,
- three flags: carry (CF), zero (ZF) and sign (SF).

Each operation writes only the outputs it defines. Every other flag, and the position, keeps its last value.

A bit operation copies the original selected bit into CF before it sets, clears or inverts that bit. A scan that finds no set bit raises ZF and leaves the position unchanged.

Top module: `btms_unit`

## Requirements
- R1: After reset, `out_vld`, `res_o`, `pos_o`, `cf_o`, `zf_o` and `sf_o` are all zero.
- R2: A request accepted with `in_vld`=1 gives `out_vld`=1 on the next clock edge. When `in_vld`=0, `out_vld` falls and every other output holds its value.
- R3: Code 0 (test) copies bit b of `opa_i` into `cf_o` and returns `opa_i` unchanged on `res_o`.
- R4: Codes 1 (set), 2 (clear) and 3 (invert) copy the original bit b into `cf_o`. They return `opa_i` with bit b forced to 1, forced to 0 or inverted, and every other bit unchanged.
- R5: The bit index b is `opb_i` modulo 64, so only `opb_i[5:0]` selects the bit.
- R6: Code 4 (masked test) returns `opa_i` unchanged and clears `cf_o`. It sets `zf_o` when `opa_i & opb_i` is zero, and copies bit 63 of that AND into `sf_o`.
- R7: Code 4 with both operands equal sets `zf_o` exactly when the operand is zero, and sets `sf_o` exactly when its bit 63 is set.
- R8: Code 5 (forward scan) writes the index of the lowest set bit of a non-zero `opa_i` to `pos_o` and clears `zf_o`. For 0x38 the index is 3.
- R9: Code 6 (reverse scan) writes the index of the highest set bit of a non-zero `opa_i` to `pos_o` and clears `zf_o`. For 0x38 the index is 5.
- R10: A scan of a zero `opa_i` sets `zf_o` and leaves `pos_o` unchanged.
- R11: Flags that an operation does not define keep their values:
  - bit operations hold ZF and SF;
  - scans hold CF and SF and return `opa_i` on `res_o`;
  - code 7 returns `opa_i` and holds all flags and `pos_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| opa_i | input | 64 | First operand, scan source |
| opb_i | input | 64 | Mask or bit index |
| out_vld | output | 1 | Result strobe, one cycle after the request |
| res_o | output | 64 | Operand after modification |
| pos_o | output | 6 | Scan position |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |

## Verification
Bit operations are driven with indices 0, 63 and values above 63. On these indices an index-decode error or a missing modulo reduction shows up in CF or in the result. Each of set, clear and invert is driven onto a bit that was already 1 and onto one that was 0, so the carry copy is checked against the original bit and not the modified one.

Scans use the patterns below, which separate the lowest-first and highest-first encoders:
- 0x38;
- a single bit at either end of the word;
- all ones;
- zero.

The scans run after a bit operation or a masked test has left known flag and position values behind. Held values can therefore be told apart from values that were rewritten.

// File: rtl/btms_pkg.sv
package btms_pkg;
  typedef enum logic [2:0] {
    OP_TEST    = 3'd0,
    OP_SET     = 3'd1,
    OP_CLR     = 3'd2,
    OP_FLIP    = 3'd3,
    OP_AND     = 3'd4,
    OP_SCAN_LO = 3'd5,
    OP_SCAN_HI = 3'd6,
    OP_PASS    = 3'd7
  } btms_op_e;
endpackage

// File: rtl/btms_bitmod.sv
module btms_bitmod
  import btms_pkg::*;
#(
  parameter int unsigned DW = 64,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic [DW-1:0] opnd_i,
  input  logic [IW-1:0] idx_i,
  input  btms_op_e      op_i,
  output logic [DW-1:0] res_o,
  output logic          bit_o
);
  logic [DW-1:0] sel;

  for (genvar g = 0; g < DW; g++) begin : g_dec
    assign sel[g] = (idx_i == IW'(g));
  end

  always_comb begin
    bit_o = |(opnd_i & sel);
    unique case (op_i)
      OP_SET:  res_o = opnd_i | sel;
      OP_CLR:  res_o = opnd_i & ~sel;
      OP_FLIP: res_o = opnd_i ^ sel;
      default: res_o = opnd_i;
    endcase
  end

  // R5: exactly one bit selected for any index value
  always_comb begin
    a_r5_sel_onehot: assert ($onehot(sel)) else $error("bit select not one-hot");
  end
endmodule

// File: rtl/btms_scan.sv
module btms_scan #(
  parameter int unsigned DW = 64,
  parameter bit HIGH_FIRST = 1'b0,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic [DW-1:0] src_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  assign found_o = |src_i;

  if (HIGH_FIRST) begin : g_hi
    always_comb begin
      idx_o = '0;
      for (int i = 0; i < DW; i++) begin
        if (src_i[i]) idx_o = IW'(i);
      end
    end
  end else begin : g_lo
    always_comb begin
      idx_o = '0;
      for (int i = DW-1; i >= 0; i--) begin
        if (src_i[i]) idx_o = IW'(i);
      end
    end
  end

  // R8 / R9: the reported position holds a set bit
  always_comb begin
    if (found_o) begin
      a_r8_pos_is_set: assert (src_i[idx_o]) else $error("scan index on clear bit");
    end
  end
endmodule

// File: rtl/btms_unit.sv
module btms_unit
  import btms_pkg::*;
#(
  parameter int unsigned DW = 64,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic          out_vld,
  output logic [DW-1:0] res_o,
  output logic [IW-1:0] pos_o,
  output logic          cf_o,
  output logic          zf_o,
  output logic          sf_o
);
  logic [1:0] rst_sync;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  btms_op_e op;
  assign op = btms_op_e'(op_i);

  logic [DW-1:0] mod_res;
  logic          sel_bit;
  logic [IW-1:0] lo_idx, hi_idx;
  logic          lo_found, hi_found;
  logic [DW-1:0] and_w;

  btms_bitmod #(.DW(DW)) u_mod (
    .opnd_i (opa_i),
    .idx_i  (opb_i[IW-1:0]),
    .op_i   (op),
    .res_o  (mod_res),
    .bit_o  (sel_bit)
  );

  btms_scan #(.DW(DW), .HIGH_FIRST(1'b0)) u_scan_lo (
    .src_i   (opa_i),
    .idx_o   (lo_idx),
    .found_o (lo_found)
  );

  btms_scan #(.DW(DW), .HIGH_FIRST(1'b1)) u_scan_hi (
    .src_i   (opa_i),
    .idx_o   (hi_idx),
    .found_o (hi_found)
  );

  assign and_w = opa_i & opb_i;

  logic [DW-1:0] res_d;
  logic [IW-1:0] pos_d;
  logic          cf_d, zf_d, sf_d;

  always_comb begin
    res_d = res_o;
    pos_d = pos_o;
    cf_d  = cf_o;
    zf_d  = zf_o;
    sf_d  = sf_o;
    if (in_vld) begin
      unique case (op)
        OP_TEST, OP_SET, OP_CLR, OP_FLIP: begin
          res_d = mod_res;
          cf_d  = sel_bit;
        end
        OP_AND: begin
          res_d = opa_i;
          cf_d  = 1'b0;
          zf_d  = ~|and_w;
          sf_d  = and_w[DW-1];
        end
        OP_SCAN_LO: begin
          res_d = opa_i;
          zf_d  = ~lo_found;
          if (lo_found) pos_d = lo_idx;
        end
        OP_SCAN_HI: begin
          res_d = opa_i;
          zf_d  = ~hi_found;
          if (hi_found) pos_d = hi_idx;
        end
        default: res_d = opa_i;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else if (!rst_ok) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      pos_o <= '0;
      cf_o  <= 1'b0;
      zf_o  <= 1'b0;
      sf_o  <= 1'b0;
    end else if (rst_ok && in_vld) begin
      res_o <= res_d;
      pos_o <= pos_d;
      cf_o  <= cf_d;
      zf_o  <= zf_d;
      sf_o  <= sf_d;
    end
  end

  // R2: strobe follows request by one cycle
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_ok)
    in_vld |=> out_vld);
  // R2: idle cycles keep all results
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_vld |=> (!out_vld && $stable(res_o) && $stable(pos_o)
                 && $stable(cf_o) && $stable(zf_o) && $stable(sf_o)));
  // R3: plain test leaves the operand intact
  a_r3_test_keeps: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_vld && op == OP_TEST) |=> res_o == $past(opa_i));
  // R4: modify touches at most one bit
  a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_vld && (op == OP_SET || op == OP_CLR || op == OP_FLIP))
    |=> $countones(res_o ^ $past(opa_i)) <= 1);
  // R10: zero scan source raises ZF and holds the position
  a_r10_zero_scan: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_vld && (op == OP_SCAN_LO || op == OP_SCAN_HI) && opa_i == '0)
    |=> (zf_o && pos_o == $past(pos_o)));
  // R11: bit operations hold ZF and SF
  a_r11_bitop_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_vld && (op == OP_TEST || op == OP_SET || op == OP_CLR || op == OP_FLIP))
    |=> ($stable(zf_o) && $stable(sf_o) && $stable(pos_o)));
endmodule

// File: tb/tb_btms_unit.sv
module tb_btms_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        out_vld;
  logic [63:0] res_o;
  logic [5:0]  pos_o;
  logic        cf_o, zf_o, sf_o;

  always #2.5 clk = ~clk;

  btms_unit dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .out_vld(out_vld), .res_o(res_o),
    .pos_o(pos_o), .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o)
  );

  typedef struct {
    logic [63:0] res;
    logic [5:0]  pos;
    logic        cf, zf, sf;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;

  logic [5:0] m_pos = '0;
  logic       m_cf = 1'b0, m_zf = 1'b0, m_sf = 1'b0;

  task automatic issue(input logic [2:0] op, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    exp_t e;
    int   ix;
    logic [63:0] r;
    ix = int'(b % 64);
    r  = a;
    case (op)
      3'd0: m_cf = a[ix];
      3'd1: begin m_cf = a[ix]; r[ix] = 1'b1; end
      3'd2: begin m_cf = a[ix]; r[ix] = 1'b0; end
      3'd3: begin m_cf = a[ix]; r[ix] = ~a[ix]; end
      3'd4: begin m_cf = 1'b0; m_zf = ((a & b) == 0); m_sf = a[63] & b[63]; end
      3'd5: begin
        m_zf = (a == 0);
        for (int i = 0; i < 64; i++) if (a[i]) begin m_pos = 6'(i); break; end
      end
      3'd6: begin
        m_zf = (a == 0);
        for (int i = 63; i >= 0; i--) if (a[i]) begin m_pos = 6'(i); break; end
      end
      default: ;
    endcase
    e.res = r; e.pos = m_pos; e.cf = m_cf; e.zf = m_zf; e.sf = m_sf; e.tag = tag;
    @(negedge clk);
    in_vld = 1'b1; op_i = op; opa_i = a; opb_i = b;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0; op_i = $urandom_range(0, 7);
    opa_i = 64'hDEAD_BEEF_0123_4567; opb_i = 64'h3;
  endtask

  always @(negedge clk) begin
    if (out_vld) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R2: unexpected out_vld, actual 1 expected 0");
      end else begin
        e = exp_q.pop_front();
        if (res_o !== e.res || pos_o !== e.pos || cf_o !== e.cf
            || zf_o !== e.zf || sf_o !== e.sf) begin
          failures++;
          $display("FAIL %s: actual res=%h pos=%0d cf=%b zf=%b sf=%b expected res=%h pos=%0d cf=%b zf=%b sf=%b",
                   e.tag, res_o, pos_o, cf_o, zf_o, sf_o,
                   e.res, e.pos, e.cf, e.zf, e.sf);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++; // R1 reset state
    if (out_vld !== 0 || res_o !== 0 || pos_o !== 0 || cf_o !== 0
        || zf_o !== 0 || sf_o !== 0) begin
      failures++;
      $display("FAIL R1: actual vld=%b res=%h pos=%0d flags=%b%b%b expected all zero",
               out_vld, res_o, pos_o, cf_o, zf_o, sf_o);
    end
    // R3 plain test
    issue(3'd0, 64'h8000_0000_0000_0001, 64'd0,  "R3");
    issue(3'd0, 64'h8000_0000_0000_0001, 64'd63, "R3");
    issue(3'd0, 64'h8000_0000_0000_0001, 64'd5,  "R3");
    // R4 modify variants, on clear and set bits
    issue(3'd1, 64'h0, 64'd10, "R4");
    issue(3'd1, 64'h400, 64'd10, "R4");
    issue(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, "R4");
    issue(3'd2, 64'h0F, 64'd7, "R4");
    issue(3'd3, 64'hF0, 64'd4, "R4");
    issue(3'd3, 64'hF0, 64'd8, "R4");
    // R5 modulo index
    issue(3'd0, 64'h40, 64'd70, "R5");
    issue(3'd1, 64'h0, 64'd67, "R5");
    issue(3'd3, 64'h1, 64'hFFFF_FFFF_FFFF_FFC0, "R5");
    // R6 masked test
    issue(3'd4, 64'hF0, 64'h0F, "R6");
    issue(3'd4, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    // R7 self test
    issue(3'd4, 64'h0, 64'h0, "R7");
    issue(3'd4, 64'hFFFF_FFFF_FFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFFB, "R7");
    issue(3'd4, 64'h5, 64'h5, "R7");
    // R11 bit op after masked test keeps ZF/SF
    issue(3'd4, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R6");
    issue(3'd1, 64'h0, 64'd2, "R11");
    // R8 / R9 scans
    issue(3'd5, 64'h38, 64'd0, "R8");
    issue(3'd6, 64'h38, 64'd0, "R9");
    issue(3'd5, 64'h8000_0000_0000_0000, 64'd0, "R8");
    issue(3'd6, 64'h1, 64'd0, "R9");
    issue(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R9");
    issue(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R8");
    // R10 zero sources hold the position
    issue(3'd6, 64'h0, 64'd0, "R10");
    issue(3'd5, 64'h0, 64'd0, "R10");
    issue(3'd5, 64'h100, 64'd0, "R8");
    // R11 pass code holds all flags and position
    issue(3'd0, 64'h1, 64'd0, "R3");
    issue(3'd7, 64'h1234, 64'd0, "R11");
    issue(3'd5, 64'h0, 64'd0, "R11");
    idle();
    repeat (2) @(negedge clk);
    snap = res_o;
    repeat (3) idle();
    @(negedge clk);
    checks++; // R2 idle holds outputs
    if (out_vld !== 1'b0 || res_o !== snap) begin
      failures++;
      $display("FAIL R2: actual vld=%b res=%h expected vld=0 res=%h", out_vld, res_o, snap);
    end
    checks++; // R2 all results drained
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2: actual pending=%0d expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule